// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a grid of push keys laid out as a set of drive lines crossed with a set of return lines. The return lines have pull-downs. A pressed key connects a driven-high line to its return. While no key is pressed the block stays quiet: the drive lines sit at a fixed idle pattern and the block only watches the returns. When any return goes high, it starts a scan pass.

A pass walks the drive lines one at a time, twice. Each line gets its own time slice, and the returns are sampled at a fixed settle offset inside that slice. At the end of the pass the two captured images are compared:
- If they agree and show at least one key, the image is latched into the key buffer and the active-low request output falls.
- If they disagree while keys are still down, the pass is repeated.
- If the later image is empty, the block goes back to idle.

The host answers a request with a one-cycle read-done strobe. That releases the request and starts a fresh pass, so a held key is reported again and again until it is let go. A two-bit sleep code selects which drive lines are held high while idle, so in a low-power setting only keys on selected lines can wake the scanner. An active-low blank input clears the buffer, withdraws the request and keeps the scanner stopped.

Top module: `kscan_matrix`

## Requirements
- R1: The key at drive line r (1-based) and return c (1-based) is reported in key buffer bit (r-1)*COLS + (c-1), with bit 0 the least significant.
- R2: With sleep code 00 and no scan in progress, all drive lines are high. A scan pass starts only on a cycle in which some return input is high.
- R3: During a scan, at most one drive line is high. Starting with line 1, each line is high for SLOT_CYC cycles in ascending order, and the sequence is run twice.
- R4: When both scans of a pass hold the same non-empty image, req_n goes low PASS_CYC clock edges after the first scanning cycle, and key_buf then holds that image.
- R5: When the two scans differ and the later one is non-empty, a new pass follows at once, so the request for a press that settles during the first pass arrives 2*PASS_CYC edges after scanning began.
- R6: While req_n is low, req_n and key_buf stay unchanged until read_done is seen. A read_done while req_n is high has no effect on req_n, key_buf or the drive lines.
- R7: The edge that samples read_done with req_n low raises req_n and starts a new pass. If keys are still down, a new request follows PASS_CYC edges later. If all keys are up, no request follows and the lines return to idle.
- R8: With no scan in progress, the drive-line pattern follows the sleep code:
  - 01 drives only the last line high.
  - 10 drives the last two lines high.
  - 11 drives every line except line 1 high.
- R9: A key on an idle-low drive line does not start a scan. A key on an idle-high line does, and it is then reported normally.
- R10: While blank_n is low, key_buf is zero, req_n is high and no scan runs, even with keys pressed. The drive lines show the idle pattern.
- R11: Several keys pressed together are all reported in one image, whatever their number.
- R12: A press released before the second scan samples it never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scanner clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_n | input | 1 | Active-low blank: clears buffer, stops scanning |
| sleep_code | input | 2 | Idle drive-line pattern select (00 = normal) |
| ret_in | input | COLS | Return lines from the key matrix, pulled low |
| read_done | input | 1 | Host strobe: the buffered image has been read |
| scan_out | output | ROWS | Drive lines to the key matrix |
| key_buf | output | ROWS*COLS | Accepted key image, row-major |
| req_n | output | 1 | Active-low read request |

## Verification
The bench builds the block with 6 drive lines and 5 returns, matching the full 30-key grid. The slice is shortened to 4 cycles with sampling at offset 2, and the pass window to 64 cycles. With these values each pass lasts under a hundred cycles, so the cycle-exact request delay, the doubled delay after a mismatch, and a release that falls between the two scans can all be hit on exact edges. Every sleep pattern, blanking during a pending request, and repeated reports of a held key fit easily in one short run.

// File: rtl/kscan_pkg.sv
`timescale 1ns/1ps
package kscan_pkg;

    localparam int unsigned KS_MAX_LINES = 16;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_SCAN = 2'd1,
        KS_WAIT = 2'd2
    } kscan_state_e;

    typedef enum logic [1:0] {
        PASS_ACCEPT  = 2'd0,
        PASS_RESCAN  = 2'd1,
        PASS_RELEASE = 2'd2
    } kscan_verdict_e;

    // Idle level of each drive line, selected by the sleep code.
    function automatic logic [KS_MAX_LINES-1:0] idle_drive(input logic [1:0] code,
                                                          input int unsigned lines);
        logic [KS_MAX_LINES-1:0] all_m;
        logic [KS_MAX_LINES-1:0] top;
        all_m = KS_MAX_LINES'((32'd1 << lines) - 32'd1);
        top   = KS_MAX_LINES'(32'd1 << (lines - 1));
        case (code)
            2'b01:   idle_drive = top;
            2'b10:   idle_drive = top | (top >> 1);
            2'b11:   idle_drive = all_m & ~KS_MAX_LINES'(1);
            default: idle_drive = all_m;
        endcase
    endfunction

    // Outcome of a completed pass from the two scan images.
    function automatic kscan_verdict_e judge(input logic same, input logic later_any);
        if (!later_any)
            judge = PASS_RELEASE;
        else if (same)
            judge = PASS_ACCEPT;
        else
            judge = PASS_RESCAN;
    endfunction

endpackage

// File: rtl/kscan_row_seq.sv
`timescale 1ns/1ps
module kscan_row_seq #(
    parameter int unsigned ROWS       = 6,
    parameter int unsigned SLOT_CYC   = 2000,
    parameter int unsigned SETTLE_CYC = 1000,
    parameter int unsigned PASS_CYC   = 25600,
    localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned SW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
    localparam int unsigned PW = (PASS_CYC > 1) ? $clog2(PASS_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [ROWS-1:0] row_oh,
    output logic [RW-1:0] row_idx,
    output logic          second,
    output logic          sample,
    output logic          pass_end
);
    logic [PW-1:0] pc_q;
    logic [SW-1:0] slot_q;
    logic [RW-1:0] row_q;
    logic          second_q;
    logic          done_q;

    assign pass_end = run && (pc_q == PW'(PASS_CYC - 1));
    assign sample   = run && !done_q && (slot_q == SW'(SETTLE_CYC));
    assign row_idx  = row_q;
    assign second   = second_q;

    always_ff @(posedge clk) begin
        if (rst || !run || pass_end) begin
            pc_q     <= '0;
            slot_q   <= '0;
            row_q    <= '0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            pc_q <= pc_q + PW'(1);
            if (!done_q) begin
                if (slot_q == SW'(SLOT_CYC - 1)) begin
                    slot_q <= '0;
                    if (row_q == RW'(ROWS - 1)) begin
                        row_q <= '0;
                        if (second_q)
                            done_q <= 1'b1;
                        else
                            second_q <= 1'b1;
                    end else begin
                        row_q <= row_q + RW'(1);
                    end
                end else begin
                    slot_q <= slot_q + SW'(1);
                end
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign row_oh[r] = run && !done_q && (row_q == RW'(r));
    end

endmodule

// File: rtl/kscan_capture.sv
`timescale 1ns/1ps
module kscan_capture #(
    parameter int unsigned ROWS = 6,
    parameter int unsigned COLS = 5,
    localparam int unsigned KEYS = ROWS * COLS,
    localparam int unsigned RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            sample,
    input  logic            second,
    input  logic [RW-1:0]   row_idx,
    input  logic [COLS-1:0] ret,
    output logic [KEYS-1:0] img_a,
    output logic [KEYS-1:0] img_b
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] a_q;
        logic [COLS-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                a_q <= '0;
                b_q <= '0;
            end else if (sample && (row_idx == RW'(r))) begin
                if (second)
                    b_q <= ret;
                else
                    a_q <= ret;
            end
        end
        assign img_a[r*COLS +: COLS] = a_q;
        assign img_b[r*COLS +: COLS] = b_q;
    end

endmodule

// File: rtl/kscan_matrix.sv
`timescale 1ns/1ps
module kscan_matrix
    import kscan_pkg::*;
#(
    parameter int unsigned ROWS       = 6,
    parameter int unsigned COLS       = 5,
    parameter int unsigned SLOT_CYC   = 2000,
    parameter int unsigned SETTLE_CYC = 1000,
    parameter int unsigned PASS_CYC   = 25600,
    localparam int unsigned KEYS = ROWS * COLS,
    localparam int unsigned RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            blank_n,
    input  logic [1:0]      sleep_code,
    input  logic [COLS-1:0] ret_in,
    input  logic            read_done,
    output logic [ROWS-1:0] scan_out,
    output logic [KEYS-1:0] key_buf,
    output logic            req_n
);
    kscan_state_e   state_q;
    logic [KEYS-1:0] buf_q;
    logic            req_n_q;

    logic            run;
    logic [ROWS-1:0] row_oh;
    logic [RW-1:0]   row_idx;
    logic            second;
    logic            sample;
    logic            pass_end;
    logic [KEYS-1:0] img_a;
    logic [KEYS-1:0] img_b;
    logic [KS_MAX_LINES-1:0] idle_full;
    kscan_verdict_e  verdict;

    assign run = blank_n && (state_q == KS_SCAN);

    kscan_row_seq #(
        .ROWS(ROWS), .SLOT_CYC(SLOT_CYC),
        .SETTLE_CYC(SETTLE_CYC), .PASS_CYC(PASS_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .run(run),
        .row_oh(row_oh), .row_idx(row_idx), .second(second),
        .sample(sample), .pass_end(pass_end)
    );

    kscan_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
        .clk(clk), .rst(rst), .clr(!run || pass_end),
        .sample(sample), .second(second), .row_idx(row_idx),
        .ret(ret_in), .img_a(img_a), .img_b(img_b)
    );

    assign idle_full = idle_drive(sleep_code, ROWS);
    assign verdict   = judge(img_a == img_b, |img_b);
    assign scan_out  = run ? row_oh : idle_full[ROWS-1:0];
    assign key_buf   = buf_q;
    assign req_n     = req_n_q;

    always_ff @(posedge clk) begin
        if (rst || !blank_n) begin
            state_q <= KS_IDLE;
            buf_q   <= '0;
            req_n_q <= 1'b1;
        end else begin
            case (state_q)
                KS_IDLE: begin
                    if (|ret_in)
                        state_q <= KS_SCAN;
                end
                KS_SCAN: begin
                    if (pass_end) begin
                        case (verdict)
                            PASS_ACCEPT: begin
                                buf_q   <= img_b;
                                req_n_q <= 1'b0;
                                state_q <= KS_WAIT;
                            end
                            PASS_RESCAN:  state_q <= KS_SCAN;
                            default:      state_q <= KS_IDLE;
                        endcase
                    end
                end
                KS_WAIT: begin
                    if (read_done) begin
                        req_n_q <= 1'b1;
                        state_q <= KS_SCAN;
                    end
                end
                default: state_q <= KS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/kscan_matrix_chk.sv
`timescale 1ns/1ps
module kscan_matrix_chk
    import kscan_pkg::*;
#(
    parameter int unsigned ROWS = 6,
    parameter int unsigned COLS = 5,
    parameter int unsigned KEYS = 30
) (
    input logic            clk,
    input logic            rst,
    input logic            blank_n,
    input logic [1:0]      sleep_code,
    input logic [COLS-1:0] ret_in,
    input logic            read_done,
    input logic [ROWS-1:0] scan_out,
    input logic [KEYS-1:0] key_buf,
    input logic            req_n,
    input kscan_state_e    st
);
    a_r3_single_line: assert property (@(posedge clk) disable iff (rst)
        (st == KS_SCAN && blank_n) |-> $onehot0(scan_out));

    a_r10_blank_clears: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> (req_n && key_buf == '0));

    a_r6_request_holds: assert property (@(posedge clk) disable iff (rst)
        (!req_n && !read_done && blank_n) |=> (!req_n && $stable(key_buf)));

    a_r4_request_has_keys: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n) |-> (key_buf != '0));

    a_r2_no_start_without_return: assert property (@(posedge clk) disable iff (rst)
        (st == KS_IDLE && ret_in == '0) |=> (st != KS_SCAN));

    a_r8_sleep_top_line: assert property (@(posedge clk) disable iff (rst)
        ((st != KS_SCAN || !blank_n) && sleep_code == 2'b01)
            |-> (scan_out == {1'b1, {(ROWS-1){1'b0}}}));

endmodule

bind kscan_matrix kscan_matrix_chk #(.ROWS(ROWS), .COLS(COLS), .KEYS(KEYS)) u_chk (
    .clk(clk), .rst(rst), .blank_n(blank_n), .sleep_code(sleep_code),
    .ret_in(ret_in), .read_done(read_done), .scan_out(scan_out),
    .key_buf(key_buf), .req_n(req_n), .st(state_q)
);

// File: tb/kscan_matrix_bench.sv
`timescale 1ns/1ps
module kscan_matrix_bench;
    localparam int ROWS = 6;
    localparam int COLS = 5;
    localparam int SLOT = 4;
    localparam int SETTLE = 2;
    localparam int PASS = 64;
    localparam int KEYS = ROWS * COLS;
    localparam int NVEC = 5;

    localparam logic [KEYS-1:0] VEC_KEYS [NVEC] = '{
        30'h0000_0001, 30'h2000_0000, 30'h0000_0020, 30'h0210_0402, 30'h0000_7C00 };
    localparam logic [KEYS-1:0] VEC_EXP [NVEC] = '{
        30'h0000_0001, 30'h2000_0000, 30'h0000_0020, 30'h0210_0402, 30'h0000_7C00 };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blank_n = 1'b1;
    logic [1:0] sleep_code = 2'b00;
    logic [COLS-1:0] ret_in;
    logic read_done = 1'b0;
    logic [ROWS-1:0] scan_out;
    logic [KEYS-1:0] key_buf;
    logic req_n;
    logic [KEYS-1:0] keys = '0;

    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    kscan_matrix #(.ROWS(ROWS), .COLS(COLS), .SLOT_CYC(SLOT),
                   .SETTLE_CYC(SETTLE), .PASS_CYC(PASS)) u_kscan_matrix (
        .clk(clk), .rst(rst), .blank_n(blank_n), .sleep_code(sleep_code),
        .ret_in(ret_in), .read_done(read_done), .scan_out(scan_out),
        .key_buf(key_buf), .req_n(req_n));

    // Key matrix model: a return is high when a pressed key joins it to a high line.
    always_comb begin
        ret_in = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (scan_out[r] && keys[r*COLS + c]) ret_in[c] = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input int limit, output int n);
        n = 0;
        while (req_n && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_read();
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
    endtask

    task automatic release_all();
        keys = '0;
        do_read();
        tick(PASS + 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [KEYS-1:0] held;
        tick(3);
        rst = 1'b0;
        tick(1);
        // Reset state
        check(req_n == 1'b1, "R6 reset req_n", req_n, 1);
        check(key_buf == '0, "R10 reset key_buf", key_buf, 0);
        check(scan_out == 6'b111111, "R2 normal idle lines", scan_out, 6'h3F);
        tick(20);
        check(scan_out == 6'b111111 && req_n, "R2 no scan without key", scan_out, 6'h3F);

        // Vector table: R1 bit numbering, R11 multiple keys
        for (int v = 0; v < NVEC; v++) begin
            keys = VEC_KEYS[v];
            wait_req(4*PASS, n);
            check(n == PASS + 1, "R4 request delay", n, PASS + 1);
            check(key_buf == VEC_EXP[v], "R1 R11 key image", key_buf, VEC_EXP[v]);
            release_all();
            check(req_n == 1'b1 && scan_out == 6'b111111, "R7 released returns idle",
                  {req_n, scan_out}, 7'h7F);
        end

        // R3: line sequence during a scan
        keys = 30'h0000_0004;
        for (int k = 1; k <= 2*ROWS*SLOT; k++) begin
            tick(1);
            check(scan_out == 6'(1 << (((k-1) / SLOT) % ROWS)), "R3 line order",
                  scan_out, 6'(1 << (((k-1) / SLOT) % ROWS)));
        end
        wait_req(4*PASS, n);
        check(n == PASS - 2*ROWS*SLOT + 1, "R4 remaining delay", n, PASS - 2*ROWS*SLOT + 1);

        // R6: request holds, stale read_done ignored
        held = key_buf;
        tick(10);
        check(!req_n && key_buf == held, "R6 hold without read", {req_n, key_buf}, {1'b0, held});
        // R7: read with key still held gives a new request
        do_read();
        check(req_n == 1'b1, "R7 req released", req_n, 1);
        wait_req(4*PASS, n);
        check(n == PASS, "R7 repeat request delay", n, PASS);
        release_all();
        held = key_buf;
        do_read();
        tick(2);
        check(req_n && key_buf == held && scan_out == 6'b111111, "R6 read_done ignored when idle",
              {req_n, key_buf}, {1'b1, held});

        // R5: key added between the two scans forces a rescan
        keys = 30'h0000_0001;
        tick(31);
        keys = 30'h0200_0001;
        wait_req(4*PASS, n);
        check(n == 2*PASS + 1 - 31, "R5 rescan delay", n + 31, 2*PASS + 1);
        check(key_buf == 30'h0200_0001, "R5 image after rescan", key_buf, 30'h0200_0001);
        release_all();

        // R12: short press released before second scan
        keys = 30'h0000_0001;
        tick(20);
        keys = '0;
        wait_req(3*PASS, n);
        check(req_n == 1'b1, "R12 short press not reported", req_n, 1);
        check(scan_out == 6'b111111, "R12 back to idle", scan_out, 6'h3F);

        // R10: blank during a pending request
        keys = 30'h0000_0100;
        wait_req(4*PASS, n);
        blank_n = 1'b0;
        tick(1);
        check(req_n && key_buf == '0, "R10 blank clears", {req_n, key_buf}, {1'b1, 30'h0});
        for (int k = 0; k < 40; k++) begin
            tick(1);
            if (k == 39)
                check(scan_out == 6'b111111 && req_n, "R10 no scan while blank", scan_out, 6'h3F);
        end
        blank_n = 1'b1;
        wait_req(4*PASS, n);
        check(n == PASS + 1 && key_buf == 30'h0000_0100, "R10 resumes after blank", n, PASS + 1);
        release_all();

        // R8: sleep idle patterns
        sleep_code = 2'b01; tick(1);
        check(scan_out == 6'b100000, "R8 code 01", scan_out, 6'h20);
        sleep_code = 2'b10; tick(1);
        check(scan_out == 6'b110000, "R8 code 10", scan_out, 6'h30);
        sleep_code = 2'b11; tick(1);
        check(scan_out == 6'b111110, "R8 code 11", scan_out, 6'h3E);

        // R9: sleep wake only from high lines
        sleep_code = 2'b01;
        keys = 30'h0000_0001;
        wait_req(2*PASS, n);
        check(req_n == 1'b1 && scan_out == 6'b100000, "R9 low line no wake",
              {req_n, scan_out}, 7'h60);
        keys = 30'h2000_0000;
        wait_req(4*PASS, n);
        check(n == PASS + 1 && key_buf == 30'h2000_0000, "R9 high line wakes", key_buf, 30'h2000_0000);
        release_all();
        check(scan_out == 6'b100000, "R8 sleep idle kept", scan_out, 6'h20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule